// File: doc/BRIEF.md
# Conduction Mode Selector for a Digitally Controlled Buck Converter

This block decides, once per switching period, whether a digitally controlled buck converter runs fixed-frequency continuous-conduction PWM or a synchronized pulse-skipping mode for light loads. It sees a small signed error code from a windowed ADC, a flag from the current sensor that says the inductor current reversed during the last period, and a battery voltage code. It drives a mode code, a command that puts the power stage in high impedance, the on-time used for each pulse-skipping pulse, and a one-period flag that lets the compensator preset its accumulator when regulation passes back to PWM.

After reset the converter ramps in open loop. The selector closes the loop once the error comes near zero. Pulse-skipping starts only after the error has stayed at zero for a programmable number of periods and the current has then reversed for a programmable number of periods in a row. In pulse-skipping mode the stage stays open until the output sits one code below the set-point. It then fires one full-length pulse per period. The on-time starts from a small table indexed by the battery code and grows by one step each time a pulse ends with reversed current. Any error outside the one-code window returns control to PWM at once.

Top module: `mode_psk_ctrl`

## Requirements
- R1: While rst_ni is low, and after its release until the first tick, mode_o is 0 (start-up), hiz_o is 0, preset_o is 0 and ton_o is 0. Mode codes: 0 start-up, 1 PWM, 2 pulse-skip open, 3 pulse-skip pulse.
- R2: In start-up, a tick with err_i (4-bit two's complement, positive meaning the output is below the set-point) in the range -1..+1 moves to PWM. Any other error keeps start-up.
- R3: In PWM, a settle counter counts consecutive ticks with err_i equal to 0 and saturates at 31. A tick with another error clears it. The selector is armed on a tick when the updated settle count is at least n1_i.
- R4: In PWM, a reverse counter counts consecutive armed ticks with rev_i high and saturates at 31. Any other tick clears it. When the updated count reaches max(n2_i,1), the selector enters pulse-skip open.
- R5: On entry to pulse-skip, ton_o loads min(floor(240/(vin_i[6:3]+1)), ton_max_i).
- R6: hiz_o is 1 exactly in pulse-skip open. There a tick with err_i = +1 moves to pulse-skip pulse, and err_i of 0 or -1 keeps the block open.
- R7: In pulse-skip pulse, a tick ends the pulse. err_i = +1 stays in pulse, and 0 or -1 returns to open.
- R8: A tick in pulse-skip pulse with rev_i high raises ton_o by 1 unless ton_o is already at least ton_max_i.
- R9: In either pulse-skip state, a tick with err_i above +1 or below -1 returns to PWM, with both counters cleared.
- R10: preset_o goes high on the tick that returns from pulse-skip to PWM and falls on the next tick. It is never high otherwise.
- R11: Cycles without a tick change neither mode_o, ton_o, preset_o nor hiz_o, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe marking the end of a switching period |
| err_i | input | 4 | Signed windowed error code, positive when output is below set-point |
| rev_i | input | 1 | Inductor current was reversed at the end of the period |
| vin_i | input | 7 | Battery voltage code, upper bits index the on-time table |
| n1_i | input | 5 | Settled periods required before pulse-skip entry |
| n2_i | input | 5 | Consecutive reverse periods required for entry |
| ton_max_i | input | 8 | Ceiling for the pulse-skip on-time |
| mode_o | output | 2 | Current mode code |
| hiz_o | output | 1 | Both power switches off |
| preset_o | output | 1 | One-period flag after returning to PWM |
| ton_o | output | 8 | On-time for pulse-skip pulses |

## Verification
The bench targets counter breaks and saturation. A single nonzero error or a single forward-current period placed just before entry would let a design that forgets to clear a counter slip into pulse-skipping early. Settings of zero for n1 or n2 check that entry still needs at least one reverse period. Window edges at +1, -1 and +2 separate a design that fires a pulse too early or leaves pulse-skipping too late. On-time saturation at a low ceiling, table loads across battery codes, and idle cycles with noisy inputs show whether on-time creeps past its limit, loads the wrong entry, or moves between ticks.

// File: rtl/mode_psk_pkg.sv
package mode_psk_pkg;
  typedef enum logic [1:0] {
    MS_START = 2'd0,
    MS_CCM   = 2'd1,
    MS_OPEN  = 2'd2,
    MS_CLOSE = 2'd3
  } mode_e;
endpackage

// File: rtl/psk_run_cnt.sv
module psk_run_cnt #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         hit_i,
  output logic [W-1:0] next_o
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};
  logic [W-1:0] cnt_q;

  always_comb begin
    if (!hit_i)            next_o = '0;
    else if (cnt_q == CMAX) next_o = cnt_q;
    else                   next_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= next_o;
  end
endmodule

// File: rtl/psk_ton_lut.sv
module psk_ton_lut #(
  parameter int AW    = 4,
  parameter int TON_W = 8,
  parameter int TON_K = 240
) (
  input  logic [AW-1:0]    idx_i,
  output logic [TON_W-1:0] val_o
);
  localparam int DEPTH = 1 << AW;
  localparam int VMAX  = (1 << TON_W) - 1;
  logic [TON_W-1:0] tbl [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    localparam int RAW = TON_K / (k + 1);
    localparam int CLP = (RAW > VMAX) ? VMAX : RAW;
    assign tbl[k] = TON_W'(CLP);
  end

  assign val_o = tbl[idx_i];
endmodule

// File: rtl/psk_ton_reg.sv
module psk_ton_reg #(
  parameter int TON_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TON_W-1:0] init_i,
  input  logic             bump_i,
  input  logic [TON_W-1:0] max_i,
  output logic [TON_W-1:0] ton_o
);
  logic [TON_W-1:0] ton_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ton_q <= '0;
    else if (load_i) ton_q <= (init_i > max_i) ? max_i : init_i;
    else if (bump_i && ton_q < max_i) ton_q <= ton_q + 1'b1;
  end

  assign ton_o = ton_q;
endmodule

// File: rtl/mode_psk_ctrl.sv
module mode_psk_ctrl
  import mode_psk_pkg::*;
#(
  parameter int ERR_W = 4,
  parameter int CNT_W = 5,
  parameter int TON_W = 8,
  parameter int VIN_W = 7,
  parameter int LUT_AW = 4,
  parameter int TON_K = 240
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic             rev_i,
  input  logic [VIN_W-1:0] vin_i,
  input  logic [CNT_W-1:0] n1_i,
  input  logic [CNT_W-1:0] n2_i,
  input  logic [TON_W-1:0] ton_max_i,
  output logic [1:0]       mode_o,
  output logic             hiz_o,
  output logic             preset_o,
  output logic [TON_W-1:0] ton_o
);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  mode_e st_q, st_d;
  logic  preset_q;

  logic signed [ERR_W-1:0] err_s;
  logic err_zero, err_up, in_win, in_ccm, in_psk;
  assign err_s    = $signed(err_i);
  assign err_zero = (err_s == 0);
  assign err_up   = (err_s == 1);
  assign in_win   = (err_s >= -1) && (err_s <= 1);
  assign in_ccm   = (st_q == MS_CCM);
  assign in_psk   = (st_q == MS_OPEN) || (st_q == MS_CLOSE);

  // consecutive-period counters, cleared by every tick outside PWM
  logic [CNT_W-1:0] set_nx, rev_nx, n2_eff;
  logic armed, enter;

  psk_run_cnt #(.W(CNT_W)) u_set_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(tick_i),
    .hit_i(in_ccm && err_zero), .next_o(set_nx)
  );

  assign armed = (set_nx >= n1_i);

  psk_run_cnt #(.W(CNT_W)) u_rev_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(tick_i),
    .hit_i(in_ccm && armed && rev_i), .next_o(rev_nx)
  );

  assign n2_eff = (n2_i == '0) ? ONE_C : n2_i;
  assign enter  = in_ccm && armed && (rev_nx >= n2_eff);

  logic [TON_W-1:0] ton_init;

  psk_ton_lut #(.AW(LUT_AW), .TON_W(TON_W), .TON_K(TON_K)) u_lut (
    .idx_i(vin_i[VIN_W-1 -: LUT_AW]), .val_o(ton_init)
  );

  psk_ton_reg #(.TON_W(TON_W)) u_ton (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(tick_i && enter), .init_i(ton_init),
    .bump_i(tick_i && (st_q == MS_CLOSE) && rev_i),
    .max_i(ton_max_i), .ton_o(ton_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      MS_START: if (in_win) st_d = MS_CCM;
      MS_CCM:   if (enter) st_d = MS_OPEN;
      MS_OPEN: begin
        if (!in_win)     st_d = MS_CCM;
        else if (err_up) st_d = MS_CLOSE;
      end
      MS_CLOSE: begin
        if (!in_win)      st_d = MS_CCM;
        else if (!err_up) st_d = MS_OPEN;
      end
      default: st_d = MS_START;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= MS_START;
      preset_q <= 1'b0;
    end else if (tick_i) begin
      st_q     <= st_d;
      preset_q <= in_psk && !in_win;
    end
  end

  assign mode_o   = st_q;
  assign hiz_o    = (st_q == MS_OPEN);
  assign preset_o = preset_q;
endmodule

// File: rtl/mode_psk_ctrl_chk.sv
module mode_psk_ctrl_chk #(
  parameter int ERR_W = 4,
  parameter int TON_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [ERR_W-1:0] err_i,
  input logic             rev_i,
  input logic [TON_W-1:0] ton_max_i,
  input logic [1:0]       mode_o,
  input logic             hiz_o,
  input logic             preset_o,
  input logic [TON_W-1:0] ton_o
);
  logic in_psk, out_win;
  assign in_psk  = mode_o[1];
  assign out_win = ($signed(err_i) > 1) || ($signed(err_i) < -1);

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(mode_o) && $stable(ton_o) && $stable(preset_o)); // R11

  AST_START_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0) |=> (mode_o == 2'd0) || (mode_o == 2'd1)); // R2

  AST_NO_PULSE_FROM_CCM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1) |=> (mode_o != 2'd3) && (mode_o != 2'd0)); // R4

  AST_WINDOW_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_psk && tick_i && out_win) |=> (mode_o == 2'd1) && preset_o && !hiz_o); // R9

  AST_PRESET_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(preset_o) |-> (mode_o == 2'd1) && $past(in_psk)); // R10

  AST_TON_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 2'd3) && tick_i && rev_i && (ton_o < ton_max_i))
      |=> ton_o == $past(ton_o) + 1'b1); // R8

  AST_TON_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 2'd3) && tick_i && !rev_i) |=> $stable(ton_o)); // R8
endmodule

bind mode_psk_ctrl mode_psk_ctrl_chk #(.ERR_W(ERR_W), .TON_W(TON_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .err_i(err_i),
  .rev_i(rev_i), .ton_max_i(ton_max_i), .mode_o(mode_o), .hiz_o(hiz_o),
  .preset_o(preset_o), .ton_o(ton_o)
);

// File: tb/sim_mode_psk_ctrl.sv
`timescale 1ns/1ps
module sim_mode_psk_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [3:0] err_i = '0;
  logic       rev_i = 1'b0;
  logic [6:0] vin_i = '0;
  logic [4:0] n1_i = 5'd2, n2_i = 5'd2;
  logic [7:0] ton_max_i = 8'd200;
  logic [1:0] mode_o;
  logic       hiz_o, preset_o;
  logic [7:0] ton_o;

  int total = 0, bad = 0, cyc = 0;
  int m_st, m_s, m_r, m_ton, m_pre;

  always #4 clk_i = ~clk_i;

  mode_psk_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .err_i(err_i),
    .rev_i(rev_i), .vin_i(vin_i), .n1_i(n1_i), .n2_i(n2_i),
    .ton_max_i(ton_max_i), .mode_o(mode_o), .hiz_o(hiz_o),
    .preset_o(preset_o), .ton_o(ton_o)
  );

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lut_val(input int vin, input int tmax);
    int v;
    v = 240 / ((vin >> 3) + 1);
    return (v > tmax) ? tmax : v;
  endfunction

  function automatic int sat31(input int v);
    return (v >= 31) ? 31 : v + 1;
  endfunction

  task automatic check_all(input string tm, input string tt);
    chk(tm, mode_o, m_st);
    chk("R6 hiz", hiz_o, (m_st == 2) ? 1 : 0);
    chk("R10 preset", preset_o, m_pre);
    chk(tt, ton_o, m_ton);
  endtask

  task automatic tick_step(input int e, input bit rv, input int vn);
    string tm, tt;
    int s_n, r_n, n2e;
    bit win, armed;
    win = (e >= -1) && (e <= 1);
    tm = "R2 mode"; tt = "R5 ton";
    m_pre = 0;
    case (m_st)
      0: begin tm = "R2 mode"; if (win) m_st = 1; end
      1: begin
        s_n = (e == 0) ? sat31(m_s) : 0;
        armed = (s_n >= int'(n1_i));
        r_n = (armed && rv) ? sat31(m_r) : 0;
        n2e = (n2_i == 0) ? 1 : int'(n2_i);
        tm = armed ? "R4 mode" : "R3 mode";
        m_s = s_n; m_r = r_n;
        if (armed && r_n >= n2e) begin
          m_st = 2; m_ton = lut_val(vn, int'(ton_max_i));
        end
      end
      2: begin
        m_s = 0; m_r = 0;
        tm = win ? "R6 mode" : "R9 mode";
        if (!win) begin m_st = 1; m_pre = 1; end
        else if (e == 1) m_st = 3;
      end
      default: begin
        m_s = 0; m_r = 0;
        tm = win ? "R7 mode" : "R9 mode";
        tt = "R8 ton";
        if (rv && m_ton < int'(ton_max_i)) m_ton++;
        if (!win) begin m_st = 1; m_pre = 1; end
        else if (e != 1) m_st = 2;
      end
    endcase
    err_i = 4'(e); rev_i = rv; vin_i = 7'(vn); tick_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    tick_i = 1'b0;
    check_all(tm, tt);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      err_i = 4'($urandom_range(0, 15));
      rev_i = 1'($urandom_range(0, 1));
      vin_i = 7'($urandom_range(0, 127));
      @(posedge clk_i);
      @(negedge clk_i);
      check_all("R11 mode", "R11 ton");
    end
  endtask

  function automatic int rnd_err();
    int p;
    p = $urandom_range(0, 99);
    if (p < 55) return 0;
    if (p < 72) return 1;
    if (p < 84) return -1;
    return $urandom_range(0, 15) - 8;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    m_st = 0; m_s = 0; m_r = 0; m_ton = 0; m_pre = 0;
    repeat (3) @(negedge clk_i);
    check_all("R1 mode", "R1 ton");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1 mode", "R1 ton");
    idle(2);

    // start-up stays out of window, then closes loop
    tick_step(5, 0, 0);
    tick_step(-3, 1, 0);
    tick_step(-1, 0, 0);

    // R3: a nonzero error breaks the settle run just before entry
    n1_i = 5'd3; n2_i = 5'd1;
    tick_step(0, 1, 8);
    tick_step(0, 1, 8);
    tick_step(1, 1, 8);
    tick_step(0, 1, 8);
    tick_step(0, 1, 8);
    tick_step(0, 1, 8);   // armed with reverse current: enters open

    // R6/R7: hold open, pulse, repeat pulse, back to open
    tick_step(0, 0, 0);
    tick_step(-1, 0, 0);
    tick_step(1, 0, 0);
    tick_step(1, 1, 0);
    tick_step(0, 1, 0);
    tick_step(2, 0, 0);   // R9 exit, preset
    tick_step(0, 0, 0);   // R10 preset falls

    // R4: n2 of zero still needs one reverse period; forward period breaks run
    n1_i = 5'd0; n2_i = 5'd0;
    tick_step(0, 0, 127);
    tick_step(3, 0, 127);
    n2_i = 5'd2;
    tick_step(0, 1, 127);
    tick_step(0, 0, 127);
    tick_step(0, 1, 127);
    tick_step(0, 1, 127);

    // R8: saturate at a low ceiling
    ton_max_i = 8'd17;
    tick_step(1, 1, 0);
    for (int i = 0; i < 5; i++) tick_step(1, 1, 0);
    tick_step(-2, 0, 0);

    // R5: ceiling below the table entry on load
    ton_max_i = 8'd50; n1_i = 5'd1; n2_i = 5'd1;
    tick_step(0, 1, 0);
    tick_step(-8, 0, 0);

    // random phase
    for (int blk = 0; blk < 40; blk++) begin
      n1_i = 5'($urandom_range(0, 4));
      n2_i = 5'($urandom_range(0, 4));
      ton_max_i = 8'($urandom_range(10, 250));
      for (int k = 0; k < 60; k++) begin
        tick_step(rnd_err(), 1'($urandom_range(0, 1)), $urandom_range(0, 127));
        idle($urandom_range(0, 2));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule